// File: doc/BRIEF.md
# One-Shot Up/Down Counter with Restart Triggers

This block is a free-standing up/down counter whose count runs between zero and a programmable top value. Counting advances one step on each clock where the count-enable input is high. Going up, the count passes from the top value back to zero. Going down, it passes from zero back to the top value. Either wrap raises a sticky wrap flag. A compare value drives a waveform output that is high while the count lies below it.

A one-shot mode can be armed with a set strobe and disarmed with a clear strobe. While the mode is armed, the counter halts at the next wrap, raises a stopped status and forces the waveform low. Three restart sources bring it back: a retrigger command, a retrigger event and a start event. Each one reloads the count to the value that fits the current direction and clears the stopped status. With the mode disarmed, the counter wraps and keeps running.

Top module: `oneshot_counter`

## Requirements
- R1: After reset, count is 0, stopped is 0, the wrap flag is 0, one-shot is disarmed, and waveOut is 1 whenever cmpVal is above 0.
- R2: With dirDown=0 and countEn=1 while running, the count rises by one per clock. From topVal it goes to 0. With one-shot disarmed, stopped stays 0 across the wrap.
- R3: With dirDown=1 and countEn=1 while running, the count falls by one per clock. From 0 it goes to topVal.
- R4: wrapFlag goes to 1 in the clock after any wrap and holds until wrapFlagClr is high. If a wrap and wrapFlagClr fall in the same clock, the flag ends at 1.
- R5: With one-shot armed, the wrap step loads the wrapped value (0 going up, topVal going down) and sets stopped to 1. After that, the count holds even with countEn high until a restart source is applied.
- R6: While stopped is 1, waveOut is 0 regardless of the count.
- R7: A high oneShotSet arms one-shot and a high oneShotClr disarms it. When both are high in the same clock, the mode ends disarmed.
- R8: A high retrigCmd, retrigEvt or startEvt clears stopped in the next clock and reloads the count to 0 (dirDown=0) or to topVal (dirDown=1). This applies whether the counter is stopped or running, and it wins over a count step in the same clock.
- R9: While stopped is 0, waveOut is 1 exactly when count is below cmpVal, compared as unsigned numbers.
- R10: With countEn=0 and no restart source, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| countEn | input | 1 | Advance the count this clock |
| dirDown | input | 1 | 1 = count down, 0 = count up |
| topVal | input | CNT_W | Highest count value |
| cmpVal | input | CNT_W | Compare value for waveOut |
| oneShotSet | input | 1 | Arm one-shot mode |
| oneShotClr | input | 1 | Disarm one-shot mode (wins over set) |
| retrigCmd | input | 1 | Restart: software-style retrigger command |
| retrigEvt | input | 1 | Restart: retrigger event |
| startEvt | input | 1 | Restart: start event |
| wrapFlagClr | input | 1 | Clear the wrap flag |
| count | output | CNT_W | Current count |
| stopped | output | 1 | Counter halted by one-shot |
| wrapFlag | output | 1 | Sticky overflow/underflow flag |
| waveOut | output | 1 | Compare-match waveform |

## Verification
A wrong stopped bit shows at the ports in the same clock: the count freezes or fails to freeze, and waveOut drops or stays high in the cycle after the wrap step. A wrong one-shot arm state is hidden until the next wrap, which can be up to topVal+1 steps away. For that reason the tests drive a full wrap after every change to the mode. A wrong reload value appears on count in the clock right after any restart source.

// File: rtl/oneshot_counter_pkg.sv
package oneshot_counter_pkg;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic reload;  // load the restart value for the current direction
    logic step;    // advance (or wrap) the count this clock
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    RUN_FREE  = 2'd0,
    RUN_ARMED = 2'd1,
    HALTED    = 2'd2
  } runState_t;

endpackage

// File: rtl/oneshot_counter_dp.sv
module oneshot_counter_dp
  import oneshot_counter_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             dirDown,
  input  logic [CNT_W-1:0] topVal,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             stopped,
  output logic [CNT_W-1:0] count,
  output logic             atWrap,
  output logic             waveOut
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countD;
  logic [CNT_W-1:0] restartVal;
  logic [CNT_W-1:0] wrapVal;
  logic [CNT_W-1:0] stepVal;

  // The wrap boundary, the reload value and the wrapped value all depend on the direction.
  assign atWrap     = dirDown ? (countQ == ZERO) : (countQ == topVal);
  assign restartVal = dirDown ? topVal : ZERO;
  assign wrapVal    = restartVal;
  assign stepVal    = dirDown ? (countQ - ONE) : (countQ + ONE);

  always_comb begin
    countD = countQ;
    if (strobe.reload) begin
      countD = restartVal;
    end else if (strobe.step) begin
      countD = atWrap ? wrapVal : stepVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= ZERO;
    else       countQ <= countD;
  end

  assign count   = countQ;
  assign waveOut = !stopped && (countQ < cmpVal);

  // A reload wins over a step.
  p_reload_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (countQ == $past(restartVal)));

endmodule

// File: rtl/oneshot_counter_ctrl.sv
module oneshot_counter_ctrl
  import oneshot_counter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        countEn,
  input  logic        atWrap,
  input  logic        oneShotSet,
  input  logic        oneShotClr,
  input  logic        retrigCmd,
  input  logic        retrigEvt,
  input  logic        startEvt,
  input  logic        wrapFlagClr,
  output ctrlStrobe_t strobe,
  output logic        stopped,
  output logic        wrapFlag,
  output logic        oneShotOn,
  output runState_t   runState
);

  logic armedQ;
  logic stoppedQ;
  logic flagQ;
  logic anyRestart;
  logic wrapStep;

  assign anyRestart    = retrigCmd | retrigEvt | startEvt;
  assign strobe.reload = anyRestart;
  assign strobe.step   = countEn && !stoppedQ && !anyRestart;
  assign wrapStep      = strobe.step && atWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (oneShotClr) begin
      armedQ <= 1'b0;  // the clear strobe wins
    end else if (oneShotSet) begin
      armedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stoppedQ <= 1'b0;
    end else if (anyRestart) begin
      stoppedQ <= 1'b0;
    end else if (wrapStep && armedQ) begin
      stoppedQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (wrapStep) begin
      flagQ <= 1'b1;  // setting wins over clearing
    end else if (wrapFlagClr) begin
      flagQ <= 1'b0;
    end
  end

  assign stopped   = stoppedQ;
  assign wrapFlag  = flagQ;
  assign oneShotOn = armedQ;

  always_comb begin
    if (stoppedQ)    runState = HALTED;
    else if (armedQ) runState = RUN_ARMED;
    else             runState = RUN_FREE;
  end

  p_clr_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    oneShotClr |=> !oneShotOn);

  p_set_arms_r7: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotSet && !oneShotClr) |=> oneShotOn);

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyRestart |=> !stopped);

  p_free_no_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!oneShotOn && !stopped) |=> !stopped);

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && atWrap) |=> wrapFlag);

endmodule

// File: rtl/oneshot_counter.sv
module oneshot_counter
  import oneshot_counter_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             dirDown,
  input  logic [CNT_W-1:0] topVal,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             oneShotSet,
  input  logic             oneShotClr,
  input  logic             retrigCmd,
  input  logic             retrigEvt,
  input  logic             startEvt,
  input  logic             wrapFlagClr,
  output logic [CNT_W-1:0] count,
  output logic             stopped,
  output logic             wrapFlag,
  output logic             waveOut
);

  ctrlStrobe_t strobe;
  logic        atWrap;
  logic        oneShotOn;
  runState_t   runState;

  oneshot_counter_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .countEn    (countEn),
    .atWrap     (atWrap),
    .oneShotSet (oneShotSet),
    .oneShotClr (oneShotClr),
    .retrigCmd  (retrigCmd),
    .retrigEvt  (retrigEvt),
    .startEvt   (startEvt),
    .wrapFlagClr(wrapFlagClr),
    .strobe     (strobe),
    .stopped    (stopped),
    .wrapFlag   (wrapFlag),
    .oneShotOn  (oneShotOn),
    .runState   (runState)
  );

  oneshot_counter_dp #(.CNT_W(CNT_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dirDown(dirDown),
    .topVal (topVal),
    .cmpVal (cmpVal),
    .stopped(stopped),
    .count  (count),
    .atWrap (atWrap),
    .waveOut(waveOut)
  );

  p_wave_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> !waveOut);

  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stopped && !strobe.reload) |=> $stable(count));

  p_armed_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (runState == RUN_ARMED && strobe.step && atWrap) |=> stopped);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !strobe.reload) |=> $stable(count));

endmodule

// File: tb/oneshot_counter_tb_top.sv
module oneshot_counter_tb_top;

  localparam int W = 8;
  localparam logic [W-1:0] TOP = 8'd5;
  localparam logic [W-1:0] CMP = 8'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countEn = 0, dirDown = 0;
  logic [W-1:0] topVal = TOP, cmpVal = CMP;
  logic oneShotSet = 0, oneShotClr = 0;
  logic retrigCmd = 0, retrigEvt = 0, startEvt = 0, wrapFlagClr = 0;
  logic [W-1:0] count;
  logic stopped, wrapFlag, waveOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  oneshot_counter #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .dirDown(dirDown),
    .topVal(topVal), .cmpVal(cmpVal), .oneShotSet(oneShotSet),
    .oneShotClr(oneShotClr), .retrigCmd(retrigCmd), .retrigEvt(retrigEvt),
    .startEvt(startEvt), .wrapFlagClr(wrapFlagClr), .count(count),
    .stopped(stopped), .wrapFlag(wrapFlag), .waveOut(waveOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    tick();
    sig = 1'b0;
  endtask

  task automatic clearFlag();
    pulse(wrapFlagClr);
    check("R4 flag cleared", wrapFlag, 0);
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 stopped", stopped, 0);
    check("R1 wrapFlag", wrapFlag, 0);
    check("R1 waveOut", waveOut, 1);
  endtask

  task automatic t_freeUp();
    countEn = 1;
    for (int i = 1; i <= 5; i++) begin
      tick();
      check("R2 up step", count, i);
      check("R9 wave", waveOut, (i < 3) ? 1 : 0);
    end
    check("R4 no flag before wrap", wrapFlag, 0);
    tick();
    check("R2 wrap to 0", count, 0);
    check("R2 still running", stopped, 0);
    check("R4 flag set", wrapFlag, 1);
    countEn = 0;
    tick(3);
    check("R10 hold", count, 0);
    check("R4 flag sticky", wrapFlag, 1);
    clearFlag();
  endtask

  task automatic t_oneShotUp();
    pulse(oneShotSet);
    countEn = 1;
    tick(5);
    check("R2 at top", count, 5);
    check("R5 not yet stopped", stopped, 0);
    tick();
    check("R5 wrapped", count, 0);
    check("R5 stopped", stopped, 1);
    check("R6 wave low", waveOut, 0);
    check("R4 flag", wrapFlag, 1);
    tick(3);
    check("R5 held", count, 0);
    check("R5 stays stopped", stopped, 1);
    check("R6 wave still low", waveOut, 0);
    countEn = 0;
    clearFlag();
  endtask

  task automatic t_retrigCmd();
    pulse(retrigCmd);
    check("R8 cmd restart", stopped, 0);
    check("R8 cmd reload up", count, 0);
    check("R9 wave back", waveOut, 1);
    countEn = 1;
    tick(3);
    check("R2 counting after restart", count, 3);
    retrigCmd = 1;
    tick();
    retrigCmd = 0;
    check("R8 reload over step", count, 0);
    countEn = 0;
  endtask

  task automatic t_oneShotDown();
    dirDown = 1;
    pulse(retrigEvt);
    check("R8 evt reload down", count, 5);
    countEn = 1;
    for (int i = 4; i >= 0; i--) begin
      tick();
      check("R3 down step", count, i);
    end
    check("R9 wave at 0", waveOut, 1);
    wrapFlagClr = 1;
    tick();
    wrapFlagClr = 0;
    check("R3 wrap to top", count, 5);
    check("R5 stopped down", stopped, 1);
    check("R4 set wins over clear", wrapFlag, 1);
    countEn = 0;
    clearFlag();
  endtask

  task automatic t_startAndModeClr();
    pulse(startEvt);
    check("R8 start restart", stopped, 0);
    check("R8 start reload down", count, 5);
    oneShotSet = 1;
    oneShotClr = 1;
    tick();
    oneShotSet = 0;
    oneShotClr = 0;
    countEn = 1;
    tick(6);
    check("R7 clear wins: wrapped", count, 5);
    check("R7 clear wins: running", stopped, 0);
    check("R4 flag", wrapFlag, 1);
    tick(2);
    check("R3 keeps counting", count, 3);
    countEn = 0;
    clearFlag();
    pulse(oneShotSet);
    pulse(oneShotClr);
    countEn = 1;
    tick(4);
    check("R7 clear strobe disarms", stopped, 0);
    check("R3 free wrap", count, 5);
    countEn = 0;
  endtask

  task automatic t_waveCmp();
    dirDown = 0;
    cmpVal = 8'd0;
    pulse(retrigCmd);
    check("R9 cmp 0 gives low", waveOut, 0);
    cmpVal = 8'd6;
    #1;
    check("R9 cmp above top", waveOut, 1);
    cmpVal = CMP;
  endtask

  initial begin
    tick(2);
    rstN = 1;
    tick();
    t_reset();
    t_freeUp();
    t_oneShotUp();
    t_retrigCmd();
    t_oneShotDown();
    t_startAndModeClr();
    t_waveCmp();
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule